// File: doc/BRIEF.md
# Manual and Time-Interval Gate Controller

This block decides when a counter's main gate opens and closes, for two measurement styles. In manual mode an operator pushbutton opens the gate on one press and closes it on the next, while the slope-conditioned channel A signal is presented as the stream to be counted. In time-interval mode the controller arms itself and then opens the gate on a chosen edge of channel A and closes it on a chosen edge of channel B. After that it holds the closed state until a re-arm pulse allows a new measurement.

The gate requests leave the block as two active-low levels, `open_n_o` and `close_n_o`, both driven from registers. Each channel has its own edge-polarity select. A common-source switch lets channel A feed the stop path as well as the start path. A range select for the time base is passed through, limited to six legal settings, while interval mode is active. In any other mode both gate requests sit high and the counted stream and range output are held at zero. All asynchronous inputs pass through synchronizers, and the pushbutton is also debounced.

Top module: `gate_seq_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `open_n_o` and `close_n_o` are high, `count_o` is 0 and `range_o` is 0.
- R2: The mode encoding is 1 = manual and 2 = interval; 0 and 3 are inactive. In an inactive mode both gate requests are high and stay high whatever the button and channels do.
- R3: On entry to manual mode the gate shows closed (`close_n_o` low, `open_n_o` high). Each accepted press (button going high) swaps open and closed.
- R4: A change of the button is accepted only after the synchronized level has held its new value for STABLE_CYCLES (default 16) consecutive clocks. A shorter pulse has no effect on the gate.
- R5: In manual mode `count_o` equals synchronized channel A XOR its slope select (0 = true polarity, 1 = inverted). Outside manual mode `count_o` is 0.
- R6: In interval mode the armed state shows both requests high. A selected channel A edge makes `open_n_o` low. A later selected stop-path edge then makes `close_n_o` low and `open_n_o` high. Both are never low together.
- R7: Each channel's slope select picks rising edges when 0 and falling edges when 1, independently per channel.
- R8: A stop edge while armed is ignored. A start edge while open or closed is ignored.
- R9: If a start edge and a stop edge arrive in the same cycle while armed, the gate opens and stays open until a later stop edge.
- R10: With `common_i` high, the stop path takes channel A and `chb_i` has no effect.
- R11: In interval mode the closed state holds until `rearm_i` is high at a clock edge, which returns the gate to armed. `rearm_i` has no effect in other states.
- R12: In interval mode `range_o` follows `range_i` for values 0 to 5, and codes 6 and 7 give 5. In other modes it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0/3 inactive, 1 manual, 2 interval |
| button_i | input | 1 | Raw pushbutton, high = pressed |
| cha_i | input | 1 | Channel A digital input |
| chb_i | input | 1 | Channel B digital input |
| slope_a_i | input | 1 | Channel A edge polarity, 1 = falling |
| slope_b_i | input | 1 | Channel B edge polarity, 1 = falling |
| common_i | input | 1 | Stop path takes channel A when high |
| range_i | input | RANGE_W | Time-base range setting |
| rearm_i | input | 1 | Re-arm after an interval measurement |
| open_n_o | output | 1 | Gate-open request, active low |
| close_n_o | output | 1 | Gate-close request, active low |
| count_o | output | 1 | Signal to be counted |
| range_o | output | RANGE_W | Range setting to the time base |

## Verification
The start and stop paths can fire in the same cycle when the common-source switch routes one channel A transition into both detectors with matching slopes. The bench provokes this by pulsing channel A while armed with `common_i` set. It expects exactly one change, to open, and then a change to closed only on the following channel A pulse. A scoreboard of expected gate transitions judges the result: any extra or missing transition of the request pair counts as a failure.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

   typedef enum logic [1:0] {
      MODE_OFF      = 2'd0,
      MODE_MANUAL   = 2'd1,
      MODE_INTERVAL = 2'd2,
      MODE_SPARE    = 2'd3
   } gsc_mode_e;

   typedef enum logic [1:0] {
      TI_ARMED = 2'd0,
      TI_OPEN  = 2'd1,
      TI_DONE  = 2'd2
   } ti_state_e;

   typedef struct packed {
      logic open_n;
      logic close_n;
   } gate_req_t;

   localparam gate_req_t GATE_IDLE   = '{open_n: 1'b1, close_n: 1'b1};
   localparam gate_req_t GATE_OPEN   = '{open_n: 1'b0, close_n: 1'b1};
   localparam gate_req_t GATE_CLOSED = '{open_n: 1'b1, close_n: 1'b0};

endpackage

// File: rtl/gsc_sync.sv
module gsc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gsc_edge_sel.sv
module gsc_edge_sel #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   input  logic falling_i,
   output logic level_o,
   output logic edge_o
);

   logic sync_s;
   logic prev_q;

   gsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (sig_i),
      .q_o  (sync_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_s;
   end

   // edges come from the raw synced value so a polarity change makes no edge
   assign edge_o  = falling_i ? (prev_q & ~sync_s) : (sync_s & ~prev_q);
   assign level_o = sync_s ^ falling_i;

endmodule

// File: rtl/gsc_debounce.sv
module gsc_debounce #(
   parameter int SYNC_STAGES   = 2,
   parameter int STABLE_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_i,
   output logic press_o
);

   localparam int CW = $clog2(STABLE_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

   logic          btn_s;
   logic          stable_q;
   logic [CW-1:0] run_q;

   gsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (btn_i),
      .q_o  (btn_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stable_q <= 1'b0;
         run_q    <= '0;
         press_o  <= 1'b0;
      end else begin
         press_o <= 1'b0;
         if (btn_s == stable_q) begin
            run_q <= '0;
         end else if (run_q == LAST) begin
            stable_q <= btn_s;
            run_q    <= '0;
            press_o  <= btn_s;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/gsc_toggle.sv
module gsc_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic enable_i,
   input  logic press_i,
   output logic is_open_o
);

   always_ff @(posedge clk) begin
      if (!rst_n)        is_open_o <= 1'b0;
      else if (!enable_i) is_open_o <= 1'b0;
      else if (press_i)   is_open_o <= ~is_open_o;
   end

endmodule

// File: rtl/gsc_interval.sv
module gsc_interval
   import gsc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      enable_i,
   input  logic      start_i,
   input  logic      stop_i,
   input  logic      rearm_i,
   output ti_state_e state_o
);

   ti_state_e nxt;

   always_comb begin
      nxt = state_o;
      unique case (state_o)
         TI_ARMED: if (start_i) nxt = TI_OPEN;
         TI_OPEN:  if (stop_i)  nxt = TI_DONE;
         TI_DONE:  if (rearm_i) nxt = TI_ARMED;
         default:               nxt = TI_ARMED;
      endcase
      if (!enable_i) nxt = TI_ARMED;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_o <= TI_ARMED;
      else        state_o <= nxt;
   end

endmodule

// File: rtl/gate_seq_ctrl.sv
module gate_seq_ctrl
   import gsc_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int STABLE_CYCLES = 16,
   parameter int RANGE_W       = 3,
   parameter int RANGE_MAX     = 5,
   parameter bit REG_COUNT     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         mode_i,
   input  logic               button_i,
   input  logic               cha_i,
   input  logic               chb_i,
   input  logic               slope_a_i,
   input  logic               slope_b_i,
   input  logic               common_i,
   input  logic [RANGE_W-1:0] range_i,
   input  logic               rearm_i,
   output logic               open_n_o,
   output logic               close_n_o,
   output logic               count_o,
   output logic [RANGE_W-1:0] range_o
);

   localparam int NUM_CH = 2;
   localparam logic [RANGE_W-1:0] RANGE_TOP = RANGE_W'(RANGE_MAX);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (STABLE_CYCLES < 2) begin : g_bad_deb
      $error("STABLE_CYCLES must be at least 2");
   end
   if (RANGE_MAX >= (1 << RANGE_W)) begin : g_bad_range
      $error("RANGE_MAX does not fit in RANGE_W bits");
   end

   logic is_manual, is_interval;
   assign is_manual   = (mode_i == MODE_MANUAL);
   assign is_interval = (mode_i == MODE_INTERVAL);

   // channel conditioning: index 0 is the start path, 1 the stop path
   logic [NUM_CH-1:0] raw, slope, lvl, edg;
   assign raw[0]   = cha_i;
   assign raw[1]   = common_i ? cha_i : chb_i;
   assign slope    = {slope_b_i, slope_a_i};

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      gsc_edge_sel #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk      (clk),
         .rst_n    (rst_n),
         .sig_i    (raw[g]),
         .falling_i(slope[g]),
         .level_o  (lvl[g]),
         .edge_o   (edg[g])
      );
   end

   logic unused_stop_level;
   assign unused_stop_level = lvl[1];

   // manual path
   logic press, man_open;

   gsc_debounce #(
      .SYNC_STAGES  (SYNC_STAGES),
      .STABLE_CYCLES(STABLE_CYCLES)
   ) u_deb (
      .clk    (clk),
      .rst_n  (rst_n),
      .btn_i  (button_i),
      .press_o(press)
   );

   gsc_toggle u_tgl (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (is_manual),
      .press_i  (press),
      .is_open_o(man_open)
   );

   // interval path
   ti_state_e ti_state;

   gsc_interval u_ti (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable_i(is_interval),
      .start_i (edg[0]),
      .stop_i  (edg[1]),
      .rearm_i (rearm_i),
      .state_o (ti_state)
   );

   // registered gate requests
   gate_req_t gate_d, gate_q;

   always_comb begin
      gate_d = GATE_IDLE;
      if (is_manual) begin
         gate_d = man_open ? GATE_OPEN : GATE_CLOSED;
      end else if (is_interval) begin
         unique case (ti_state)
            TI_OPEN: gate_d = GATE_OPEN;
            TI_DONE: gate_d = GATE_CLOSED;
            default: gate_d = GATE_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) gate_q <= GATE_IDLE;
      else        gate_q <= gate_d;
   end

   assign open_n_o  = gate_q.open_n;
   assign close_n_o = gate_q.close_n;

   // range pass-through, limited to the legal settings
   logic [RANGE_W-1:0] range_q;

   always_ff @(posedge clk) begin
      if (!rst_n)           range_q <= '0;
      else if (!is_interval) range_q <= '0;
      else                   range_q <= (range_i > RANGE_TOP) ? RANGE_TOP : range_i;
   end

   assign range_o = range_q;

   // counted stream
   if (REG_COUNT) begin : g_cnt_reg
      logic count_q;
      always_ff @(posedge clk) begin
         if (!rst_n) count_q <= 1'b0;
         else        count_q <= is_manual & lvl[0];
      end
      assign count_o = count_q;
   end else begin : g_cnt_comb
      assign count_o = is_manual & lvl[0];
   end

endmodule

// File: rtl/gsc_checker.sv
module gsc_checker
   import gsc_pkg::*;
#(
   parameter int RANGE_W   = 3,
   parameter int RANGE_MAX = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         mode_i,
   input logic               rearm_i,
   input logic               open_n_o,
   input logic               close_n_o,
   input logic               count_o,
   input logic [RANGE_W-1:0] range_o
);

   assert_never_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (open_n_o || close_n_o));

   assert_forced_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != MODE_MANUAL && mode_i != MODE_INTERVAL) |=> (open_n_o && close_n_o));

   assert_count_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != MODE_MANUAL && $past(mode_i) != MODE_MANUAL) |-> !count_o);

   assert_range_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
      range_o <= RANGE_W'(RANGE_MAX));

   assert_range_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != MODE_INTERVAL) |=> (range_o == '0));

   assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_INTERVAL && $past(mode_i) == MODE_INTERVAL &&
       !$past(rearm_i) && !close_n_o) |=> !close_n_o);

endmodule

bind gate_seq_ctrl gsc_checker #(
   .RANGE_W  (RANGE_W),
   .RANGE_MAX(RANGE_MAX)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_i   (mode_i),
   .rearm_i  (rearm_i),
   .open_n_o (open_n_o),
   .close_n_o(close_n_o),
   .count_o  (count_o),
   .range_o  (range_o)
);

// File: tb/gate_seq_ctrl_bench.sv
module gate_seq_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int RW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode = 2'd0;
   logic button = 0, cha = 0, chb = 0, sa = 0, sb = 0, common = 0, rearm = 0;
   logic [RW-1:0] range_in = '0;
   logic open_n, close_n, count;
   logic [RW-1:0] range_out;

   int tests = 0;
   int fails = 0;

   logic [1:0] q_val[$];
   string      q_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   gate_seq_ctrl u_gate_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .button_i(button),
      .cha_i(cha), .chb_i(chb), .slope_a_i(sa), .slope_b_i(sb),
      .common_i(common), .range_i(range_in), .rearm_i(rearm),
      .open_n_o(open_n), .close_n_o(close_n), .count_o(count),
      .range_o(range_out)
   );

   // gate pair {open_n, close_n}: 11 idle/armed, 01 open, 10 closed
   task automatic expect_gate(input logic [1:0] v, input string tag);
      q_val.push_back(v);
      q_tag.push_back(tag);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_a;
      cha = 1'b1; idle(8); cha = 1'b0; idle(8);
   endtask

   task automatic pulse_b;
      chb = 1'b1; idle(8); chb = 1'b0; idle(8);
   endtask

   task automatic press_btn;
      button = 1'b1; idle(40); button = 1'b0; idle(40);
   endtask

   task automatic do_rearm;
      rearm = 1'b1; idle(1); rearm = 1'b0; idle(6);
   endtask

   // monitor: every change of the request pair must match the next expected item
   logic [1:0] last_gate = 2'b11;
   always @(negedge clk) begin
      if (rst_n && ({open_n, close_n} !== last_gate)) begin
         tests++;
         if (q_val.size() == 0) begin
            fails++;
            $display("FAIL unexpected gate change: actual %b expected %b",
                     {open_n, close_n}, last_gate);
         end else begin
            logic [1:0] e;
            string      t;
            e = q_val.pop_front();
            t = q_tag.pop_front();
            if ({open_n, close_n} !== e) begin
               fails++;
               $display("FAIL %s: gate actual %b expected %b", t, {open_n, close_n}, e);
            end
         end
         last_gate = {open_n, close_n};
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      idle(5);
      // R1: reset state
      chk({open_n, close_n} == 2'b11, "R1 gate in reset", {open_n, close_n}, 3);
      chk(count == 1'b0, "R1 count in reset", count, 0);
      rst_n = 1'b1;
      idle(1);
      chk({open_n, close_n} == 2'b11, "R1 gate after reset", {open_n, close_n}, 3);
      chk(range_out == '0, "R1 range after reset", range_out, 0);

      // R2: inactive mode ignores button and channels
      press_btn();
      pulse_a();
      pulse_b();
      chk({open_n, close_n} == 2'b11, "R2 inactive holds idle", {open_n, close_n}, 3);

      // R3: manual mode starts closed and toggles per press
      expect_gate(2'b10, "R3 enter manual");
      mode = 2'd1; idle(6);
      expect_gate(2'b01, "R3 first press opens");
      press_btn();
      expect_gate(2'b10, "R3 second press closes");
      press_btn();
      // R4: short glitches are rejected
      button = 1'b1; idle(6); button = 1'b0; idle(30);
      button = 1'b1; idle(12); button = 1'b0; idle(30);
      chk({open_n, close_n} == 2'b10, "R4 glitch ignored", {open_n, close_n}, 2);

      // R5: counted stream with slope polarity
      cha = 1'b1; idle(6);
      chk(count == 1'b1, "R5 count true polarity", count, 1);
      sa = 1'b1; idle(6);
      chk(count == 1'b0, "R5 count inverted high", count, 0);
      cha = 1'b0; idle(6);
      chk(count == 1'b1, "R5 count inverted low", count, 1);
      sa = 1'b0; idle(6);

      // R6/R12: interval mode, armed
      expect_gate(2'b11, "R6 enter interval armed");
      mode = 2'd2; range_in = 3'd3; idle(6);
      chk(count == 1'b0, "R5 count zero outside manual", count, 0);
      chk(range_out == 3'd3, "R12 range pass", range_out, 3);
      range_in = 3'd7; idle(3);
      chk(range_out == 3'd5, "R12 range clamp 7", range_out, 5);
      range_in = 3'd5; idle(3);
      chk(range_out == 3'd5, "R12 range top", range_out, 5);

      // R8: stop while armed ignored
      pulse_b();
      chk({open_n, close_n} == 2'b11, "R8 stop ignored when armed", {open_n, close_n}, 3);
      expect_gate(2'b01, "R6 start opens");
      pulse_a();
      pulse_a(); // R8: start ignored while open
      expect_gate(2'b10, "R6 stop closes");
      pulse_b();
      pulse_a(); // R8: start ignored while closed
      idle(10);
      chk({open_n, close_n} == 2'b10, "R8 start ignored when closed", {open_n, close_n}, 2);
      pulse_b();
      chk({open_n, close_n} == 2'b10, "R11 closed holds without rearm", {open_n, close_n}, 2);
      expect_gate(2'b11, "R11 rearm returns armed");
      do_rearm();

      // R7: falling edges on both channels
      sa = 1'b1; sb = 1'b1;
      cha = 1'b1; idle(10);
      chk({open_n, close_n} == 2'b11, "R7 rising A ignored when falling selected", {open_n, close_n}, 3);
      expect_gate(2'b01, "R7 falling A opens");
      cha = 1'b0; idle(10);
      chb = 1'b1; idle(10);
      chk({open_n, close_n} == 2'b01, "R7 rising B ignored when falling selected", {open_n, close_n}, 1);
      expect_gate(2'b10, "R7 falling B closes");
      chb = 1'b0; idle(10);
      expect_gate(2'b11, "R11 rearm after slope test");
      do_rearm();
      sa = 1'b0; sb = 1'b0; idle(4);

      // R9/R10: common source, start and stop in the same cycle
      common = 1'b1; idle(4);
      pulse_b();
      chk({open_n, close_n} == 2'b11, "R10 chb ignored in common mode", {open_n, close_n}, 3);
      expect_gate(2'b01, "R9 coincident start and stop opens");
      pulse_a();
      chk({open_n, close_n} == 2'b01, "R9 stays open after coincidence", {open_n, close_n}, 1);
      pulse_b();
      expect_gate(2'b10, "R10 next A edge closes");
      pulse_a();
      expect_gate(2'b11, "R11 rearm after common test");
      do_rearm();
      common = 1'b0; idle(4);

      // R11: rearm while armed does nothing
      do_rearm();
      chk({open_n, close_n} == 2'b11, "R11 rearm in armed ignored", {open_n, close_n}, 3);

      // R2: leaving interval while open forces idle
      expect_gate(2'b01, "R6 open before mode exit");
      pulse_a();
      expect_gate(2'b11, "R2 leave interval forces idle");
      mode = 2'd0; idle(6);
      chk(range_out == '0, "R12 range zero outside interval", range_out, 0);
      expect_gate(2'b10, "R3 re-enter manual closed");
      mode = 2'd1; idle(6);
      expect_gate(2'b01, "R3 press opens again");
      press_btn();
      expect_gate(2'b11, "R2 spare mode forces idle");
      mode = 2'd3; idle(6);
      press_btn();
      chk({open_n, close_n} == 2'b11, "R2 spare mode ignores button", {open_n, close_n}, 3);

      idle(5);
      chk(q_val.size() == 0, "R6 all expected transitions seen", q_val.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule